// File: doc/BRIEF.md
# Dual-Channel Parallel DAC Latch Front End

This block is the digital front end of a two-channel, 12-bit digital-to-analog converter that takes a whole code word in a single write. A host drives a 12-bit data bus, an active-low select for each channel and one active-low write strobe that both channels share. Each channel has a single code register, and that register alone sets the converter code for the channel.

The host bus is asynchronous to the block, so the block samples every bus signal into its own clock domain. It then imitates a level-sensitive transparent latch. While a channel is selected and the strobe is low, the channel register follows the bus on every clock. When the latch closes, the register holds the last bus word it received. Pulling both selects low during one write loads the same word into both channels. Each channel also gives a one-clock pulse when its register closes on a new value.

Top module: `dual_dac_latch_if`

## Requirements
- R1: While reset is applied, both channel codes read 12'h000 and both update pulses are low.
- R2: With the channel A select low and the write strobe low, the channel A code takes the bus word and the channel B code does not change.
- R3: With the channel B select low and the write strobe low, the channel B code takes the bus word and the channel A code does not change.
- R4: With both selects low and the write strobe low, both channel codes take the same bus word.
- R5: While the write strobe is high, bus and select activity changes neither code.
- R6: While both selects are high, a low write strobe changes neither code.
- R7: When the write strobe rises, the code freezes at the bus word that was present just before the rise. A bus change made at the moment of the rise, or after it, is ignored.
- R8: An open latch follows every bus change. A bus change reaches the code on the third rising clock edge after it, and not on the second.
- R9: Each time a channel's latch closes, its update pulse goes high for exactly one clock, giving one pulse per closing.
- R10: Raising a channel's select while the strobe is still low also closes that latch. Bus changes that follow are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 12 | Host data bus, asynchronous |
| sel_a_n | input | 1 | Channel A select, active low |
| sel_b_n | input | 1 | Channel B select, active low |
| wr_n | input | 1 | Shared write strobe, active low |
| code_a | output | 12 | Channel A code register |
| code_b | output | 12 | Channel B code register |
| upd_a | output | 1 | One-clock pulse when channel A's latch closes |
| upd_b | output | 1 | One-clock pulse when channel B's latch closes |

## Verification
The table of write cycles runs through every select combination. Single-select rows show that the other channel keeps its value. Broadcast rows show that both channels get the same word. Rows with neither channel selected show that no transfer takes place. The data words include all zeros, all ones and the values on each side of the midscale carry, so a stuck or swapped bit shows up. Directed tests change the bus while a latch is held open, which separates transparent behaviour from an edge capture and measures the three-clock latency. Changing the bus at the same moment the strobe rises shows whether data and strobe stay aligned. Releasing a select while the strobe is low shows that the select alone can close a latch.

// File: rtl/dual_dac_latch_if.sv
module dual_dac_latch_if #(
  parameter int DW          = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_data,
  input  logic          sel_a_n,
  input  logic          sel_b_n,
  input  logic          wr_n,
  output logic [DW-1:0] code_a,
  output logic [DW-1:0] code_b,
  output logic          upd_a,
  output logic          upd_b
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] wr_pipe, sa_pipe, sb_pipe;
  logic [DW-1:0]          dat_pipe [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pipe <= '1;
      sa_pipe <= '1;
      sb_pipe <= '1;
      for (int i = 0; i < SYNC_STAGES; i++) dat_pipe[i] <= '0;
    end else begin
      wr_pipe <= {wr_pipe[SYNC_STAGES-2:0], wr_n};
      sa_pipe <= {sa_pipe[SYNC_STAGES-2:0], sel_a_n};
      sb_pipe <= {sb_pipe[SYNC_STAGES-2:0], sel_b_n};
      dat_pipe[0] <= bus_data;
      for (int i = 1; i < SYNC_STAGES; i++) dat_pipe[i] <= dat_pipe[i-1];
    end
  end

  logic          wr_s, sa_s, sb_s;
  logic [DW-1:0] data_s;
  assign wr_s   = wr_pipe[LAST];
  assign sa_s   = sa_pipe[LAST];
  assign sb_s   = sb_pipe[LAST];
  assign data_s = dat_pipe[LAST];

  logic open_a, open_b, open_a_q, open_b_q;
  assign open_a = ~wr_s & ~sa_s;
  assign open_b = ~wr_s & ~sb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_a   <= '0;
      code_b   <= '0;
      open_a_q <= 1'b0;
      open_b_q <= 1'b0;
      upd_a    <= 1'b0;
      upd_b    <= 1'b0;
    end else begin
      open_a_q <= open_a;
      open_b_q <= open_b;
      upd_a    <= open_a_q & ~open_a;
      upd_b    <= open_b_q & ~open_b;
      if (open_a) code_a <= data_s;
      if (open_b) code_b <= data_s;
    end
  end

endmodule

module dual_dac_latch_if_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_s,
  input logic          sa_s,
  input logic          sb_s,
  input logic [DW-1:0] data_s,
  input logic [DW-1:0] code_a,
  input logic [DW-1:0] code_b,
  input logic          upd_a,
  input logic          upd_b
);

  AST_A_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_s && !sa_s) |=> code_a == $past(data_s)); // R2
  AST_B_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_s && !sb_s) |=> code_b == $past(data_s)); // R3
  AST_BROADCAST_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_s && !sa_s && !sb_s) |=> code_a == code_b); // R4
  AST_A_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_s |=> ($stable(code_a) && $stable(code_b))); // R5
  AST_HELD_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (sa_s && sb_s) |=> ($stable(code_a) && $stable(code_b))); // R6
  AST_UPD_A_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_a |=> !upd_a); // R9
  AST_UPD_B_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_b |=> !upd_b); // R9

endmodule

bind dual_dac_latch_if dual_dac_latch_if_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_s(wr_s), .sa_s(sa_s), .sb_s(sb_s),
  .data_s(data_s), .code_a(code_a), .code_b(code_b),
  .upd_a(upd_a), .upd_b(upd_b)
);

// File: tb/test_dual_dac_latch_if.sv
module test_dual_dac_latch_if;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_data = '0;
  logic        sel_a_n = 1'b1, sel_b_n = 1'b1, wr_n = 1'b1;
  logic [11:0] code_a, code_b;
  logic        upd_a, upd_b;

  int errors = 0;
  int checks = 0;
  int cnt_a = 0, cnt_b = 0;
  int dbl = 0;

  always #2 clk = ~clk;

  dual_dac_latch_if i_dual_dac_latch_if (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .wr_n(wr_n),
    .code_a(code_a), .code_b(code_b), .upd_a(upd_a), .upd_b(upd_b)
  );

  logic upd_a_q = 1'b0, upd_b_q = 1'b0;
  always @(posedge clk) begin
    if (upd_a) cnt_a++;
    if (upd_b) cnt_b++;
    if ((upd_a && upd_a_q) || (upd_b && upd_b_q)) dbl++;
    upd_a_q <= upd_a;
    upd_b_q <= upd_b;
  end

  // {sel_a_n, sel_b_n, data, expected code_a, expected code_b}
  localparam logic [37:0] VEC [8] = '{
    {1'b0, 1'b1, 12'hA5C, 12'hA5C, 12'h000},
    {1'b1, 1'b0, 12'h3F1, 12'hA5C, 12'h3F1},
    {1'b0, 1'b0, 12'h7FF, 12'h7FF, 12'h7FF},
    {1'b1, 1'b1, 12'h123, 12'h7FF, 12'h7FF},
    {1'b0, 1'b1, 12'h800, 12'h800, 12'h7FF},
    {1'b1, 1'b0, 12'hFFF, 12'h800, 12'hFFF},
    {1'b0, 1'b0, 12'h000, 12'h000, 12'h000},
    {1'b1, 1'b0, 12'h001, 12'h000, 12'h001}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcycle(input logic sa, input logic sb, input logic [11:0] d);
    @(negedge clk);
    bus_data = d; sel_a_n = sa; sel_b_n = sb; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    sel_a_n = 1'b1; sel_b_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 code_a in reset", code_a, 0);
    chk("R1 code_b in reset", code_b, 0);
    chk("R1 upd in reset", {upd_a, upd_b}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      int ea0, eb0;
      ea0 = cnt_a; eb0 = cnt_b;
      wcycle(VEC[i][37], VEC[i][36], VEC[i][35:24]);
      chk($sformatf("R2/R3/R4/R6 vec%0d code_a", i), code_a, VEC[i][23:12]);
      chk($sformatf("R2/R3/R4/R6 vec%0d code_b", i), code_b, VEC[i][11:0]);
      chk($sformatf("R9 vec%0d upd_a pulses", i), cnt_a - ea0, VEC[i][37] ? 0 : 1);
      chk($sformatf("R9 vec%0d upd_b pulses", i), cnt_b - eb0, VEC[i][36] ? 0 : 1);
    end
    // state now: code_a=000, code_b=001

    // R5: strobe high, selects low, bus moving
    @(negedge clk);
    sel_a_n = 1'b0; sel_b_n = 1'b0; bus_data = 12'hBAD;
    repeat (3) @(negedge clk);
    bus_data = 12'h5A5;
    repeat (4) @(negedge clk);
    chk("R5 code_a with strobe high", code_a, 12'h000);
    chk("R5 code_b with strobe high", code_b, 12'h001);
    sel_a_n = 1'b1; sel_b_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: transparency and latency
    bus_data = 12'h111; sel_a_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 first word", code_a, 12'h111);
    bus_data = 12'h222;
    repeat (2) @(negedge clk);
    chk("R8 not yet after two edges", code_a, 12'h111);
    @(negedge clk);
    chk("R8 follows after three edges", code_a, 12'h222);
    // R7: bus changes at the same moment the strobe rises
    bus_data = 12'h333; wr_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 frozen at last word", code_a, 12'h222);
    chk("R7 other channel untouched", code_b, 12'h001);
    sel_a_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: select released while strobe still low
    begin
      int ea0;
      ea0 = cnt_a;
      bus_data = 12'h6C3; sel_a_n = 1'b0; wr_n = 1'b0;
      repeat (4) @(negedge clk);
      sel_a_n = 1'b1;
      repeat (2) @(negedge clk);
      bus_data = 12'h999;
      repeat (4) @(negedge clk);
      chk("R10 frozen by select release", code_a, 12'h6C3);
      chk("R10 one pulse on close", cnt_a - ea0, 1);
      wr_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R10 no pulse on later strobe rise", cnt_a - ea0, 1);
    end

    chk("R9 no double-wide pulse", dbl, 0);

    // R1: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 code_a cleared", code_a, 0);
    chk("R1 code_b cleared", code_b, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule